// File: doc/BRIEF.md
# Four-Pin Bidirectional GPIO Port

This block is a four-pin general-purpose I/O port hanging off a single-cycle, byte-wide register bus with a 16-bit address. It has two registers. The data latch holds the value driven onto output pins. The direction register selects, for each pin, whether the pad driver is enabled. Pad inputs pass through a two-stage synchronizer before software can observe them.

A read of the data address returns a per-bit mix. Pins configured as outputs return the latched value. Pins configured as inputs return the synchronized pad level. The direction register accepts writes, but a read of its address always returns all ones. Only the low four bits of each register exist. The high four bits are reserved and read as ones.

Top module: `gpio4_port`

## Requirements
- R1: Bits 7..4 of every read of the data address return 1. Values written to bits 7..4 of either register are discarded.
- R2: While reset is low and after it is released, padOe and padOut are 0. A data read with all pins low returns 0xF0.
- R3: A write (cs=1, we=1) to address 0xFFED stores wdata[3:0] as the direction. From the next clock, padOe equals the stored value, and a bit of 1 enables the output driver for that pin.
- R4: A write to address 0xFFDD stores wdata[3:0] in the data latch whatever the direction. From the next clock, padOut equals the stored value.
- R5: On a data read, bit i (i = 0..3) returns latch bit i when direction bit i is 1. It returns the synchronized pad bit i when direction bit i is 0.
- R6: The pad level seen by a data read is the one present two rising clock edges earlier. A change on padIn is invisible after one edge and visible after the second.
- R7: A read with cs=1 at address 0xFFED returns 0xFF.
- R8: A read at any other address, or with cs=0, returns 0xFF. A write at any other address, or with we=0, changes neither register.
- R9: rdata is combinational. In the cycle of a write, it shows the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Bus select for this cycle |
| we | input | 1 | Write strobe, qualified by cs |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| padIn | input | 4 | Asynchronous pad input levels |
| padOe | output | 4 | Per-pin output driver enable |
| padOut | output | 4 | Per-pin output value |

## Verification
Two functions can fall in the same cycle: a write that changes the data latch and a read returning the latch through the read mux. The bench holds a write to the data address with cs high, then samples rdata before the clock edge. That sample must show the old latch contents. The sample after the edge must show the new contents. In a second overlap, a pad input changes while a data read is held. The bench judges it by checking that the first edge leaves rdata unchanged and that the second edge brings the new level through.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
  localparam int ADDR_W      = 16;
  localparam int BUS_W       = 8;
  localparam int PINS        = 4;
  localparam int SYNC_STAGES = 2;
  localparam logic [ADDR_W-1:0] LATCH_ADDR = 16'hFFDD;
  localparam logic [ADDR_W-1:0] DIR_ADDR   = 16'hFFED;

  // strobes from decode to datapath
  typedef struct packed {
    logic wrLatch;
    logic wrDir;
    logic selLatch;
    logic selDir;
  } portStrobe_t;
endpackage

// File: rtl/gpio4_ctrl.sv
module gpio4_ctrl
  import gpio4_pkg::*;
#(
  parameter logic [ADDR_W-1:0] latchAddr = LATCH_ADDR,
  parameter logic [ADDR_W-1:0] dirAddr   = DIR_ADDR
) (
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output portStrobe_t       strobe
);
  logic hitLatch, hitDir;

  always_comb begin
    hitLatch        = cs && (addr == latchAddr);
    hitDir          = cs && (addr == dirAddr);
    strobe.selLatch = hitLatch;
    strobe.selDir   = hitDir;
    strobe.wrLatch  = hitLatch && we;
    strobe.wrDir    = hitDir && we;
  end
endmodule

// File: rtl/gpio4_dpath.sv
module gpio4_dpath
  import gpio4_pkg::*;
#(
  parameter int nPins   = PINS,
  parameter int busW    = BUS_W,
  parameter int nStages = SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [busW-1:0]  wdata,
  input  logic [nPins-1:0] padIn,
  output logic [nPins-1:0] padOe,
  output logic [nPins-1:0] padOut,
  output logic [busW-1:0]  rdata
);
  localparam int RSV_W = busW - nPins;

  logic [nPins-1:0] latchQ, dirQ;
  logic [nPins-1:0] syncQ [nStages];
  logic [nPins-1:0] pinLevel;
  logic [nPins-1:0] mixed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
    end else begin
      if (strobe.wrLatch) latchQ <= wdata[nPins-1:0];
      if (strobe.wrDir)   dirQ   <= wdata[nPins-1:0];
    end
  end

  // input synchronizer chain
  generate
    for (genvar s = 0; s < nStages; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN)   syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else         syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinLevel = syncQ[nStages-1];

  // per-bit readback selection
  generate
    for (genvar b = 0; b < nPins; b++) begin : g_mix
      assign mixed[b] = dirQ[b] ? latchQ[b] : pinLevel[b];
    end
  endgenerate

  always_comb begin
    if (strobe.selLatch) rdata = {{RSV_W{1'b1}}, mixed};
    else                 rdata = '1;
  end

  assign padOe  = dirQ;
  assign padOut = latchQ;
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
  import gpio4_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   padOut
);
  portStrobe_t strobe;

  gpio4_ctrl #(.latchAddr(LATCH_ADDR), .dirAddr(DIR_ADDR)) u_ctrl (
    .cs(cs), .we(we), .addr(addr), .strobe(strobe)
  );

  gpio4_dpath #(.nPins(PINS), .busW(BUS_W), .nStages(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(wdata),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .rdata(rdata)
  );
endmodule

// File: rtl/gpio4_checker.sv
module gpio4_checker
  import gpio4_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cs,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wdata,
  input logic [BUS_W-1:0]  rdata,
  input logic [PINS-1:0]   padIn,
  input logic [PINS-1:0]   padOe,
  input logic [PINS-1:0]   padOut
);
  logic [1:0] upCnt;
  always_ff @(posedge clk) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd2) upCnt <= upCnt + 2'd1;
  end

  AST_RESERVED_ONES: assert property (@(posedge clk) disable iff (!rstN)
    rdata[BUS_W-1:PINS] == '1);  // R1
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (padOe == '0 && padOut == '0));  // R2
  AST_DIR_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (cs && we && addr == DIR_ADDR) |=> padOe == $past(wdata[PINS-1:0]));  // R3
  AST_LATCH_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (cs && we && addr == LATCH_ADDR) |=> padOut == $past(wdata[PINS-1:0]));  // R4
  AST_OUT_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (cs && addr == LATCH_ADDR) |-> ((rdata[PINS-1:0] & padOe) == (padOut & padOe)));  // R5
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == 2'd2 && cs && addr == LATCH_ADDR && padOe == '0)
      |-> rdata[PINS-1:0] == $past(padIn, 2));  // R6
  AST_DIR_READS_FF: assert property (@(posedge clk) disable iff (!rstN)
    (cs && addr == DIR_ADDR) |-> rdata == '1);  // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(cs && we && (addr == DIR_ADDR || addr == LATCH_ADDR))
      |=> ($stable(padOe) && $stable(padOut)));  // R8
endmodule

bind gpio4_port gpio4_checker u_chk (.*);

// File: tb/gpio4_port_bench.sv
module gpio4_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  padIn = '0;
  logic [3:0]  padOe, padOut;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gpio4_port u_gpio4_port (.*);

  typedef struct packed {
    logic        wr;
    logic [15:0] a;
    logic [7:0]  d;
    logic [3:0]  pad;
    logic [7:0]  expRd;
    logic [3:0]  expOe;
    logic [3:0]  expOut;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'hFFDD, 8'h00, 4'hA, 8'hFA, 4'h0, 4'h0},  // R5 all inputs
    '{1'b1, 16'hFFDD, 8'h35, 4'hA, 8'h00, 4'h0, 4'h5},  // R4 R1 latch while input
    '{1'b0, 16'hFFDD, 8'h00, 4'h3, 8'hF3, 4'h0, 4'h5},  // R5
    '{1'b1, 16'hFFED, 8'hC6, 4'h3, 8'h00, 4'h6, 4'h5},  // R3 R1
    '{1'b0, 16'hFFDD, 8'h00, 4'h9, 8'hFD, 4'h6, 4'h5},  // R5 mixed
    '{1'b0, 16'hFFED, 8'h00, 4'h9, 8'hFF, 4'h6, 4'h5},  // R7
    '{1'b0, 16'hFFDC, 8'h00, 4'h9, 8'hFF, 4'h6, 4'h5},  // R8 undecoded read
    '{1'b1, 16'hFFEE, 8'hFF, 4'h9, 8'h00, 4'h6, 4'h5},  // R8 undecoded write
    '{1'b1, 16'hFFED, 8'h0F, 4'h9, 8'h00, 4'hF, 4'h5},  // R3
    '{1'b0, 16'hFFDD, 8'h00, 4'h0, 8'hF5, 4'hF, 4'h5},  // R5 all outputs
    '{1'b1, 16'hFFDD, 8'h0A, 4'h0, 8'h00, 4'hF, 4'hA},  // R4
    '{1'b0, 16'hFFDD, 8'h00, 4'hF, 8'hFA, 4'hF, 4'hA}   // R5
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cs = 1'b0; we = 1'b0;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R2 reset state
    repeat (3) @(negedge clk);
    chk("R2 oe in reset", {4'h0, padOe}, 8'h00);
    rstN = 1'b1;
    idle(3);
    cs = 1'b1; addr = 16'hFFDD; #1;
    chk("R2 data read", rdata, 8'hF0);
    chk("R2 out", {padOe, padOut}, 8'h00);
    idle(1);

    // table walk
    for (int k = 0; k < NV; k++) begin
      padIn = VECS[k].pad;
      idle(3);
      cs = 1'b1; we = VECS[k].wr; addr = VECS[k].a; wdata = VECS[k].d;
      #1;
      if (!VECS[k].wr) chk($sformatf("R5/R7/R8 vec %0d rdata", k), rdata, VECS[k].expRd);
      @(negedge clk);
      cs = 1'b0; we = 1'b0; #1;
      chk($sformatf("R3/R4/R8 vec %0d pads", k), {padOe, padOut},
          {VECS[k].expOe, VECS[k].expOut});
    end

    // R9: read while writing the latch (dir is F, latch A)
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = 16'hFFDD; wdata = 8'h03; #1;
    chk("R9 old value during write", rdata, 8'hFA);
    @(negedge clk);
    we = 1'b0; #1;
    chk("R9 new value after edge", rdata, 8'hF3);

    // R6: two-edge synchronizer latency, all pins input
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = 16'hFFED; wdata = 8'h00;
    @(negedge clk);
    we = 1'b0; addr = 16'hFFDD; padIn = 4'h0;
    idle(3);
    cs = 1'b1; addr = 16'hFFDD; padIn = 4'h6; #1;
    chk("R6 before edges", rdata, 8'hF0);
    @(negedge clk); #1;
    chk("R6 after one edge", rdata, 8'hF0);
    @(negedge clk); #1;
    chk("R6 after two edges", rdata, 8'hF6);

    // R8: cs low reads FF, write with we low ignored
    cs = 1'b0; #1;
    chk("R8 cs low", rdata, 8'hFF);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = 16'hFFDD; wdata = 8'h0C;
    @(negedge clk); #1;
    chk("R8 we low ignored", {4'h0, padOut}, 8'h03);

    // R1: reserved write bits do not show
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = 16'hFFED; wdata = 8'h0F;
    @(negedge clk);
    we = 1'b1; addr = 16'hFFDD; wdata = 8'h00;
    @(negedge clk);
    we = 1'b0; #1;
    chk("R1 reserved read ones", rdata, 8'hF0);

    // R2: reset mid-run
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1; padIn = 4'h0;
    idle(3);
    cs = 1'b1; addr = 16'hFFDD; #1;
    chk("R2 after second reset", rdata, 8'hF0);
    chk("R2 pads after second reset", {padOe, padOut}, 8'h00);
    idle(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule